// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This block connects the load/store stage of a 16-bit core to a byte-addressed data RAM built from two byte-wide lanes. The lanes share one word index and have separate write enables. Each cycle the core may present one access: an effective address, a size flag (byte or word), a direction, write data, the present value of the destination register, a post-increment flag and an extend mode for byte loads. One clock later the unit returns the read result already merged into register format, the post-modified pointer value and, for a misaligned word access, a one-cycle address-error trap strobe. It also keeps the faulting address and direction for later inspection.

The RAM window starts at `RAM_BASE` and spans `2*RAM_WORDS` bytes. The base must be aligned to that span. Every other address is unimplemented: the special-register region 0x0000-0x07FF and everything above the RAM window read as zero and ignore writes. A small state machine classifies each cycle's access into one of five states: `ACC_IDLE` (no access), `ACC_READ`, `ACC_WRITE`, `ACC_RD_FAULT` (misaligned word read) and `ACC_WR_FAULT` (misaligned word write). Its outputs are decoded from the state held for the cycle after the access. Every state can move to any state on the next clock. The transition is named by the request: none goes to `ACC_IDLE`; an aligned read or any byte read goes to `ACC_READ`; an aligned write or any byte write goes to `ACC_WRITE`; an odd-address word read goes to `ACC_RD_FAULT`; and an odd-address word write goes to `ACC_WR_FAULT`.

Top module: `dmem_access_unit`

## Requirements
- R1: A byte read of RAM returns the lane chosen by address bit 0 (0 = low byte, 1 = high byte of the containing word) on `rd_data[7:0]`.
- R2: A byte write to RAM changes only the byte lane selected by address bit 0. The other byte of the same word keeps its value.
- R3: A word access (`req_byte`=0) with address bit 0 set pulses `trap_pulse` in the cycle after the request, for that cycle only. In the same cycle `trap_ea` takes the faulting address and `trap_is_write` takes its direction (1 = write). Both hold until the next trap.
- R4: A misaligned word read still completes. `rd_valid` rises, and `rd_data` carries the word at the address with bit 0 cleared.
- R5: A misaligned word write asserts no lane write enable. No RAM byte changes.
- R6: With `req_ext`=2'b00 (and the unused code 2'b11), a byte read returns `dst_old[15:8]` unchanged in `rd_data[15:8]`.
- R7: With `req_ext`=2'b01, a byte read clears `rd_data[15:8]`. With `req_ext`=2'b10, it fills `rd_data[15:8]` with copies of the loaded byte's bit 7. Word reads ignore `req_ext`.
- R8: `ptr_out` equals the access address plus 1 for a byte access or plus 2 for a word access when `req_postinc` is 1, and the unchanged address when it is 0, modulo 2^16. This holds for faulting accesses too.
- R9: Reads outside the RAM window, including the region 0x0000-0x07FF, return a zero byte or word. Writes there change nothing.
- R10: While reset is asserted and in the first cycle after it, `acc_done`, `rd_valid`, `trap_pulse`, `rd_data`, `ptr_out`, `trap_ea` and `trap_is_write` are all zero.
- R11: `acc_done` (and `rd_valid` for reads) is high exactly one cycle after a request. A write is visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte size, 0 = word size |
| req_postinc | input | 1 | Post-increment the pointer |
| req_ext | input | 2 | Byte-load format: 00 keep high byte, 01 zero-extend, 10 sign-extend, 11 as 00 |
| req_ea | input | 16 | Effective byte address |
| req_wdata | input | 16 | Store data; byte stores use bits [7:0] |
| dst_old | input | 16 | Current destination register value |
| acc_done | output | 1 | An access completed last cycle |
| rd_valid | output | 1 | `rd_data` holds a load result |
| rd_data | output | 16 | Load result in register format |
| ptr_out | output | 16 | Post-modified pointer |
| trap_pulse | output | 1 | One-cycle address-error strobe |
| trap_ea | output | 16 | Address of the latest faulting access |
| trap_is_write | output | 1 | Direction of the latest faulting access |

## Verification
The assertions assume that the core drives the request inputs to zero while reset is held. They also assume that `req_ext` and `dst_old` are meaningful only with a valid byte read, and that the checks of lane write enables depend only on the request fields of the same cycle. The stimulus changes inputs only on the falling clock edge and keeps `req_valid` low during reset. It draws addresses from a fixed-seed generator weighted toward the RAM window, while still reaching the special-register region, the space above RAM and odd addresses on word accesses. It fills the RAM through the block's own write path before any random read, so every expected value is known.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

    typedef enum logic [1:0] {
        EXT_KEEP = 2'b00,
        EXT_ZERO = 2'b01,
        EXT_SIGN = 2'b10,
        EXT_RSVD = 2'b11
    } ext_mode_e;

    typedef enum logic [2:0] {
        ACC_IDLE     = 3'd0,
        ACC_READ     = 3'd1,
        ACC_WRITE    = 3'd2,
        ACC_RD_FAULT = 3'd3,
        ACC_WR_FAULT = 3'd4
    } acc_state_e;

    localparam int unsigned LANES = 2;
    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/dmau_lane_ram.sv
module dmau_lane_ram #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wbyte,
    output logic [DATA_W-1:0] rbyte
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wbyte;
        end
        if (rd_en) begin
            rbyte <= mem[idx];
        end
    end

endmodule

// File: rtl/dmau_addr_dec.sv
module dmau_addr_dec #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned RAM_BASE  = 32'h0800,
    parameter int unsigned RAM_WORDS = 256,
    localparam int unsigned IDX_W    = $clog2(RAM_WORDS),
    localparam int unsigned RAM_END  = RAM_BASE + 2 * RAM_WORDS
) (
    input  logic              valid,
    input  logic              write,
    input  logic              is_byte,
    input  logic              postinc,
    input  logic [ADDR_W-1:0] ea,
    output logic              misalign,
    output logic              ram_hit,
    output logic              rd_en,
    output logic [IDX_W-1:0]  idx,
    output logic [1:0]        lane_we,
    output logic [ADDR_W-1:0] ptr_next
);

    logic [31:0] ea_wide;
    logic [ADDR_W-1:0] step;

    always_comb begin
        ea_wide  = 32'(ea);
        misalign = !is_byte && ea[0];
        ram_hit  = (ea_wide >= RAM_BASE) && (ea_wide < RAM_END);
        idx      = ea[IDX_W:1];
        rd_en    = valid && !write && ram_hit;
        for (int ln = 0; ln < 2; ln++) begin
            lane_we[ln] = valid && write && ram_hit && !misalign
                          && (!is_byte || (ea[0] == ln[0]));
        end
        if (!postinc) begin
            step = '0;
        end else if (is_byte) begin
            step = ADDR_W'(1);
        end else begin
            step = ADDR_W'(2);
        end
        ptr_next = ea + step;
    end

endmodule

// File: rtl/dmau_merge.sv
module dmau_merge
    import dmau_pkg::*;
(
    input  logic [15:0] word_in,
    input  logic        sel_hi,
    input  logic        is_byte,
    input  ext_mode_e   ext,
    input  logic [7:0]  hi_keep,
    output logic [15:0] data_out
);

    logic [7:0] pick;

    always_comb begin
        pick = sel_hi ? word_in[15:8] : word_in[7:0];
        if (!is_byte) begin
            data_out = word_in;
        end else begin
            unique case (ext)
                EXT_ZERO: data_out = {8'h00, pick};
                EXT_SIGN: data_out = {{8{pick[7]}}, pick};
                EXT_KEEP,
                EXT_RSVD: data_out = {hi_keep, pick};
                default:  data_out = {hi_keep, pick};
            endcase
        end
    end

endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit
    import dmau_pkg::*;
#(
    parameter int unsigned RAM_BASE  = 32'h0800,
    parameter int unsigned RAM_WORDS = 256,
    localparam int unsigned ADDR_W   = 16,
    localparam int unsigned DATA_W   = 16,
    localparam int unsigned IDX_W    = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic              req_postinc,
    input  logic [1:0]        req_ext,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dst_old,
    output logic              acc_done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr_out,
    output logic              trap_pulse,
    output logic [ADDR_W-1:0] trap_ea,
    output logic              trap_is_write
);

    logic              misalign;
    logic              ram_hit;
    logic              rd_en;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        lane_we;
    logic [ADDR_W-1:0] ptr_next;
    logic [DATA_W-1:0] lane_wdata;
    logic [DATA_W-1:0] lane_rdata;

    acc_state_e state_q, state_d;

    logic       hit_q;
    logic       sel_hi_q;
    logic       byte_q;
    ext_mode_e  ext_q;
    logic [7:0] keep_q;
    logic [DATA_W-1:0] word_seen;
    logic [DATA_W-1:0] merged;

    dmau_addr_dec #(
        .ADDR_W    (ADDR_W),
        .RAM_BASE  (RAM_BASE),
        .RAM_WORDS (RAM_WORDS)
    ) u_dec (
        .valid    (req_valid),
        .write    (req_write),
        .is_byte  (req_byte),
        .postinc  (req_postinc),
        .ea       (req_ea),
        .misalign (misalign),
        .ram_hit  (ram_hit),
        .rd_en    (rd_en),
        .idx      (idx),
        .lane_we  (lane_we),
        .ptr_next (ptr_next)
    );

    // a byte store carries its data on bits [7:0]; copy it to both lanes
    assign lane_wdata = req_byte ? {req_wdata[7:0], req_wdata[7:0]} : req_wdata;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        dmau_lane_ram #(
            .DEPTH  (RAM_WORDS),
            .DATA_W (LANE_W)
        ) u_lane (
            .clk   (clk),
            .we    (lane_we[ln]),
            .rd_en (rd_en),
            .idx   (idx),
            .wbyte (lane_wdata[ln*LANE_W +: LANE_W]),
            .rbyte (lane_rdata[ln*LANE_W +: LANE_W])
        );
    end

    // next-state classification of this cycle's request
    always_comb begin
        if (!req_valid) begin
            state_d = ACC_IDLE;
        end else if (req_write) begin
            state_d = misalign ? ACC_WR_FAULT : ACC_WRITE;
        end else begin
            state_d = misalign ? ACC_RD_FAULT : ACC_READ;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // access context captured with the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q         <= 1'b0;
            sel_hi_q      <= 1'b0;
            byte_q        <= 1'b0;
            ext_q         <= EXT_KEEP;
            keep_q        <= '0;
            ptr_out       <= '0;
            trap_ea       <= '0;
            trap_is_write <= 1'b0;
        end else if (req_valid) begin
            hit_q    <= ram_hit;
            sel_hi_q <= req_ea[0];
            byte_q   <= req_byte;
            ext_q    <= ext_mode_e'(req_ext);
            keep_q   <= dst_old[15:8];
            ptr_out  <= ptr_next;
            if (misalign) begin
                trap_ea       <= req_ea;
                trap_is_write <= req_write;
            end
        end
    end

    assign word_seen = hit_q ? lane_rdata : '0;

    dmau_merge u_merge (
        .word_in  (word_seen),
        .sel_hi   (sel_hi_q),
        .is_byte  (byte_q),
        .ext      (ext_q),
        .hi_keep  (keep_q),
        .data_out (merged)
    );

    // output decode from the state
    always_comb begin
        acc_done   = 1'b0;
        rd_valid   = 1'b0;
        trap_pulse = 1'b0;
        rd_data    = '0;
        unique case (state_q)
            ACC_IDLE: begin
            end
            ACC_READ: begin
                acc_done = 1'b1;
                rd_valid = 1'b1;
                rd_data  = merged;
            end
            ACC_WRITE: begin
                acc_done = 1'b1;
            end
            ACC_RD_FAULT: begin
                acc_done   = 1'b1;
                rd_valid   = 1'b1;
                rd_data    = merged;
                trap_pulse = 1'b1;
            end
            ACC_WR_FAULT: begin
                acc_done   = 1'b1;
                trap_pulse = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dmau_checker.sv
module dmau_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_byte,
    input logic        req_postinc,
    input logic [1:0]  req_ext,
    input logic [15:0] req_ea,
    input logic [15:0] dst_old,
    input logic [1:0]  lane_we,
    input logic        acc_done,
    input logic        rd_valid,
    input logic [15:0] rd_data,
    input logic [15:0] ptr_out,
    input logic        trap_pulse,
    input logic [15:0] trap_ea,
    input logic        trap_is_write
);

    AST_TRAP_ON_ODD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_byte && req_ea[0]) |=> trap_pulse) else $error("trap missing"); // R3

    AST_NO_TRAP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_byte && req_ea[0]) |=> !trap_pulse) else $error("spurious trap"); // R3

    AST_TRAP_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_byte && req_ea[0]) |=> (trap_ea == $past(req_ea)) && (trap_is_write == $past(req_write))) else $error("trap context"); // R3

    AST_NO_WE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_byte && req_ea[0]) |-> (lane_we == 2'b00)) else $error("fault write"); // R5

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_byte) |-> $countones(lane_we) <= 1) else $error("two lanes"); // R2

    AST_READ_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rd_valid && acc_done)) else $error("read late"); // R11

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ptr_out == 16'($past(req_ea) + ($past(req_postinc) ? ($past(req_byte) ? 16'd1 : 16'd2) : 16'd0))) else $error("pointer"); // R8

    AST_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_byte && (req_ext == 2'b00)) |=> rd_data[15:8] == $past(dst_old[15:8])) else $error("high byte"); // R6

    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_byte && (req_ext == 2'b10)) |=> rd_data[15:8] == {8{rd_data[7]}}) else $error("sign fill"); // R7

endmodule

bind dmem_access_unit dmau_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_byte      (req_byte),
    .req_postinc   (req_postinc),
    .req_ext       (req_ext),
    .req_ea        (req_ea),
    .dst_old       (dst_old),
    .lane_we       (lane_we),
    .acc_done      (acc_done),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .ptr_out       (ptr_out),
    .trap_pulse    (trap_pulse),
    .trap_ea       (trap_ea),
    .trap_is_write (trap_is_write)
);

// File: tb/sim_dmem_access_unit.sv
module sim_dmem_access_unit;

    localparam int unsigned BASE  = 32'h0800;
    localparam int unsigned BYTES = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_byte = 1'b0;
    logic        req_postinc = 1'b0;
    logic [1:0]  req_ext = 2'b00;
    logic [15:0] req_ea = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] dst_old = '0;
    logic        acc_done;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [15:0] ptr_out;
    logic        trap_pulse;
    logic [15:0] trap_ea;
    logic        trap_is_write;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0]  model [BYTES];
    logic [15:0] exp_tea = '0;
    logic        exp_twr = 1'b0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    dmem_access_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_byte(req_byte), .req_postinc(req_postinc), .req_ext(req_ext),
        .req_ea(req_ea), .req_wdata(req_wdata), .dst_old(dst_old),
        .acc_done(acc_done), .rd_valid(rd_valid), .rd_data(rd_data),
        .ptr_out(ptr_out), .trap_pulse(trap_pulse), .trap_ea(trap_ea),
        .trap_is_write(trap_is_write)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_ram(input logic [15:0] ea);
        return (32'(ea) >= BASE) && (32'(ea) < BASE + BYTES);
    endfunction

    function automatic logic [7:0] mbyte(input logic [15:0] ea);
        if (!in_ram(ea)) return 8'h00;
        return model[32'(ea) - BASE];
    endfunction

    function automatic logic [15:0] exp_read(input logic [15:0] ea, input bit byt,
                                            input logic [1:0] ext, input logic [15:0] dst);
        logic [7:0] b;
        logic [15:0] even;
        even = {ea[15:1], 1'b0};
        if (!byt) return {mbyte(even + 16'd1), mbyte(even)};
        b = mbyte(ea);
        case (ext)
            2'b01:   return {8'h00, b};
            2'b10:   return {{8{b[7]}}, b};
            default: return {dst[15:8], b};
        endcase
    endfunction

    function automatic logic [15:0] exp_ptr(input logic [15:0] ea, input bit byt, input bit pi);
        if (!pi) return ea;
        return ea + (byt ? 16'd1 : 16'd2);
    endfunction

    // one access: drive at falling edge, check at the next falling edge
    task automatic access(input bit wr, input bit byt, input bit pi, input logic [1:0] ext,
                          input logic [15:0] ea, input logic [15:0] wd, input logic [15:0] dst);
        bit odd_word;
        logic [15:0] er;
        odd_word = !byt && ea[0];
        er = exp_read(ea, byt, ext, dst);
        req_valid = 1'b1; req_write = wr; req_byte = byt; req_postinc = pi;
        req_ext = ext; req_ea = ea; req_wdata = wd; dst_old = dst;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr && !odd_word && in_ram(ea)) begin
            if (byt) model[32'(ea) - BASE] = wd[7:0];
            else begin
                model[32'(ea) - BASE] = wd[7:0];
                model[32'(ea) - BASE + 1] = wd[15:8];
            end
        end
        if (odd_word) begin exp_tea = ea; exp_twr = wr; end
        check("R11 acc_done", 32'(acc_done), 32'd1);
        check("R11 rd_valid", 32'(rd_valid), 32'(!wr));
        if (!wr) begin
            if (odd_word) check("R4 misaligned read data", 32'(rd_data), 32'(er));
            else if (!in_ram(ea)) check("R9 unimplemented read", 32'(rd_data), 32'(er));
            else if (byt) check("R1 R6 R7 byte read", 32'(rd_data), 32'(er));
            else check("R11 word read", 32'(rd_data), 32'(er));
        end
        check("R8 pointer", 32'(ptr_out), 32'(exp_ptr(ea, byt, pi)));
        check("R3 trap strobe", 32'(trap_pulse), 32'(odd_word));
        check("R3 trap address", 32'(trap_ea), 32'(exp_tea));
        check("R3 trap direction", 32'(trap_is_write), 32'(exp_twr));
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R3 strobe ends", 32'(trap_pulse), 32'd0);
        check("R11 idle done", 32'(acc_done), 32'd0);
    endtask

    function automatic logic [15:0] rand_ea();
        int unsigned sel;
        sel = $urandom_range(0, 99);
        if (sel < 70) return 16'(BASE + $urandom_range(0, BYTES - 1));
        if (sel < 85) return 16'($urandom_range(0, 16'h07FF));
        return 16'($urandom_range(BASE + BYTES, 16'hFFFF));
    endfunction

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        check("R10 reset acc_done", 32'(acc_done), 32'd0);
        check("R10 reset trap", 32'(trap_pulse), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset outputs", {rd_valid, trap_is_write, rd_data}, 32'd0);
        check("R10 after reset pointer", {ptr_out, trap_ea}, 32'd0);

        // fill the RAM through the write path
        for (int i = 0; i < BYTES; i += 2)
            access(1'b1, 1'b0, 1'b0, 2'b00, 16'(BASE + i), 16'($urandom()), 16'h0);

        // directed corner cases
        access(1'b1, 1'b0, 1'b1, 2'b00, 16'h0810, 16'hA55A, 16'h0);
        access(1'b1, 1'b1, 1'b1, 2'b00, 16'h0811, 16'h00C3, 16'h0);
        access(1'b0, 1'b0, 1'b0, 2'b00, 16'h0810, 16'h0, 16'h0);
        check("R2 high lane only", 32'(rd_data), 32'h0000C35A);
        access(1'b1, 1'b1, 1'b0, 2'b00, 16'h0810, 16'h0081, 16'h0);
        access(1'b0, 1'b1, 1'b0, 2'b10, 16'h0810, 16'h0, 16'h1234);
        check("R7 sign extend", 32'(rd_data), 32'h0000FF81);
        access(1'b0, 1'b1, 1'b0, 2'b01, 16'h0810, 16'h0, 16'h1234);
        check("R7 zero extend", 32'(rd_data), 32'h00000081);
        access(1'b0, 1'b1, 1'b1, 2'b00, 16'h0811, 16'h0, 16'hBE00);
        check("R6 R1 keep high", 32'(rd_data), 32'h0000BEC3);
        access(1'b1, 1'b0, 1'b1, 2'b00, 16'h0811, 16'hFFFF, 16'h0);
        idle_check();
        access(1'b0, 1'b0, 1'b0, 2'b00, 16'h0810, 16'h0, 16'h0);
        check("R5 suppressed write", 32'(rd_data), 32'h0000C381);
        access(1'b0, 1'b0, 1'b1, 2'b00, 16'h0811, 16'h0, 16'h0);
        check("R4 read completes", 32'(rd_data), 32'h0000C381);
        access(1'b1, 1'b0, 1'b0, 2'b00, 16'h0200, 16'h7777, 16'h0);
        access(1'b0, 1'b0, 1'b0, 2'b00, 16'h0200, 16'h0, 16'h0);
        check("R9 special region zero", 32'(rd_data), 32'h0);
        access(1'b0, 1'b0, 1'b1, 2'b00, 16'hFFFF, 16'h0, 16'h0);
        idle_check();

        // constrained random traffic
        for (int k = 0; k < 4000; k++) begin
            access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                   rand_ea(), 16'($urandom()), 16'($urandom()));
            if ($urandom_range(0, 9) == 0) idle_check();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule